// File: doc/BRIEF.md
# Bus Master Cycle Strobe Generator

This block carries out one 16-bit transfer at a time as bus master on a multiplexed address/data bus with a 24-bit address. A client presents a request with these fields:

- the address
- the direction
- word or byte size
- the byte lane
- the write data
- a flag that marks FIFO traffic

The block then asks for the bus with `hold` and waits for `hlda`. It drives the address for a two-cycle address phase and then holds the data phase until `ready` is sampled high. On a read it returns the captured word on `rd_data` with a one-cycle `done` pulse.

Three configuration bits shape the cycle, and each is taken with the request:

- **Byte-lane signalling.** Either two byte-mask pins, or a byte-flag pin read together with address bit 0.
- **Strobe style.** Either a latch enable or a short address pulse.
- **Byte swap.** Applies to FIFO data only.

In byte-flag mode the second lane pin becomes a bus-acknowledge daisy-chain output. It passes a grant downstream when this block is not asking for the bus.

Top module: `bus_master_strobe`

## Requirements
- R1: An accepted request (`req_valid` high while idle) raises `hold` at the next clock edge. `pins_oe` stays low until the edge that samples `hlda` high, and it is high from the cycle after that edge.
- R2: The address phase lasts two cycles. In both, `dal_out` equals `req_addr[15:0]`, `dal_oe` is high and `adr_hi` equals `req_addr[23:16]`.
- R3: With `cfg_pulse_strobe`=0 (latch-enable style), `strobe` is 1 in the first address cycle, 0 in the second, and stays 0 through the data phase.
- R4: With `cfg_pulse_strobe`=1 (pulse style), `strobe` is 0 in the first address cycle and 1 from the second address cycle through the data phase. Its rising edge marks the address capture point.
- R5: With `cfg_byte_pins`=0, `{lane1,lane0}` during the cycle is 00 for a word, 01 for the upper byte and 10 for the lower byte. The lane is taken from `req_upper`, and `req_addr[0]` plays no part in it.
- R6: With `cfg_byte_pins`=1, `lane0` carries the byte flag (1 = byte), and the lane comes from address bit 0 (0 = lower, 1 = upper). `req_upper` is ignored in this mode. A word request with address bit 0 = 1 is illegal. It pulses `req_err` one cycle after it is presented, and `hold` stays low.
- R7: With `cfg_byte_pins`=1, `lane1` is the chain output. It is 0 when `hlda` is high while `hold` is low, and 1 otherwise, including the whole time the block holds the bus.
- R8: With `cfg_swap`=1 and `req_fifo`=1, the data bytes trade lanes, both on the write data and on the read word returned. Non-FIFO transfers and addresses are never swapped.
- R9: In the data phase a write drives the data with `dal_oe`=1, and a read leaves `dal_oe`=0. The phase lasts until `ready` is sampled high. At that edge `hold` drops, `done` pulses for one cycle and a read's word appears on `rd_data`.
- R10: `pins_oe` (enable for `adr_hi`, `strobe`, `lane0`) is high only in the address and data phases. `lane1_oe` is high in those phases or whenever `cfg_byte_pins`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request, accepted while idle |
| req_addr | input | 24 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte transfer |
| req_upper | input | 1 | Byte lane in byte-mask mode (1 = upper) |
| req_fifo | input | 1 | Data belongs to FIFO traffic |
| req_wdata | input | 16 | Write data |
| cfg_byte_pins | input | 1 | 0 = byte-mask pins, 1 = byte flag plus chain output |
| cfg_pulse_strobe | input | 1 | 0 = latch-enable strobe, 1 = address pulse |
| cfg_swap | input | 1 | Swap bytes of FIFO data |
| hlda | input | 1 | Bus grant |
| ready | input | 1 | Slave ready in data phase |
| dal_in | input | 16 | Multiplexed bus as seen by the block |
| hold | output | 1 | Bus request |
| dal_out | output | 16 | Multiplexed bus drive value |
| dal_oe | output | 1 | Multiplexed bus drive enable |
| adr_hi | output | 8 | Upper address lines |
| strobe | output | 1 | Address latch enable or address strobe |
| lane0 | output | 1 | Byte mask 0 or byte flag |
| lane1 | output | 1 | Byte mask 1 or chain output |
| pins_oe | output | 1 | Drive enable for adr_hi, strobe, lane0 |
| lane1_oe | output | 1 | Drive enable for lane1 |
| rd_data | output | 16 | Captured read word |
| done | output | 1 | One-cycle transfer completion pulse |
| req_err | output | 1 | One-cycle illegal-request pulse |

## Verification
The hardest case to reach is the one where the cycle must not advance. The bench holds `hlda` low for an extra cycle after `hold` rises, and it holds `ready` low for an extra data-phase cycle. It then checks that no pin drive begins early and that the data phase does not end early. The stimulus also covers two mode interactions. Swap is enabled on non-FIFO transfers and on a FIFO transfer at a swap-sensitive address, to show that only data moves lanes. The chain output is exercised while idle with the grant both high and low, and again during a transfer that this block owns.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADR1,
        ST_ADR2,
        ST_DATA
    } bus_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              is_byte;
        logic              upper;
        logic              fifo;
        logic              byte_pins;
        logic              pulse;
        logic              swap;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    function automatic logic [DATA_W-1:0] swap_halves(input logic [DATA_W-1:0] w);
        return {w[HALF_W-1:0], w[DATA_W-1:HALF_W]};
    endfunction

    function automatic logic bad_combo(input logic byte_pins, input logic is_byte, input logic a0);
        return byte_pins & ~is_byte & a0;
    endfunction

    // {lane1, lane0} while master; lane1 is replaced by the chain in byte-flag mode
    function automatic logic [1:0] lane_code(input logic byte_pins, input logic is_byte,
                                             input logic upper);
        if (byte_pins)     return {1'b1, is_byte};
        else if (!is_byte) return 2'b00;
        else if (upper)    return 2'b01;
        else               return 2'b10;
    endfunction
endpackage

// File: rtl/bmc_seq.sv
module bmc_seq
    import bmc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    hlda,
    input  logic    ready,
    output bus_st_e state,
    output logic    hold,
    output logic    master,
    output logic    done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            done <= (state == ST_DATA) && ready;
            case (state)
                ST_IDLE: if (start) state <= ST_REQ;
                ST_REQ:  if (hlda)  state <= ST_ADR1;
                ST_ADR1: state <= ST_ADR2;
                ST_ADR2: state <= ST_DATA;
                ST_DATA: if (ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign hold   = (state != ST_IDLE);
    assign master = (state == ST_ADR1) || (state == ST_ADR2) || (state == ST_DATA);

    // R9
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && !ready) |=> (state == ST_DATA));
    // R1
    pins_need_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(master) |-> $past(hlda));
    // R9
    done_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(ready));
endmodule

// File: rtl/bmc_lanes.sv
module bmc_lanes
    import bmc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_st_e state,
    input  logic    master,
    input  logic    hold,
    input  logic    hlda,
    input  logic    cfg_byte_pins,
    input  logic    byte_pins_q,
    input  logic    pulse_q,
    input  logic    is_byte_q,
    input  logic    upper_q,
    input  logic    a0_q,
    output logic    strobe,
    output logic    lane0,
    output logic    lane1,
    output logic    pins_oe,
    output logic    lane1_oe
);
    logic [1:0] code;
    logic       sel_upper;

    // byte-flag mode takes the lane from the latched address bit 0
    assign sel_upper = byte_pins_q ? a0_q : upper_q;
    assign code      = master ? lane_code(byte_pins_q, is_byte_q, sel_upper) : 2'b11;

    assign strobe   = (state == ST_ADR1) ? ~pulse_q : pulse_q;
    assign lane0    = code[0];
    assign lane1    = cfg_byte_pins ? ~(hlda & ~hold) : code[1];
    assign pins_oe  = master;
    assign lane1_oe = cfg_byte_pins | master;

    // R3
    ale_close_chk: assert property (@(posedge clk) disable iff (rst)
        (!pulse_q && state == ST_ADR2) |-> $fell(strobe));
    // R4
    as_open_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_q && state == ST_ADR2) |-> $rose(strobe));
endmodule

// File: rtl/bmc_data.sv
module bmc_data
    import bmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_st_e           state,
    input  logic              ready,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              write_q,
    input  logic              fifo_q,
    input  logic              swap_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] dal_in,
    output logic [DATA_W-1:0] dal_out,
    output logic              dal_oe,
    output logic [HI_W-1:0]   adr_hi,
    output logic [DATA_W-1:0] rd_data
);
    logic do_swap;
    logic adr_ph;

    assign do_swap = swap_q & fifo_q;
    assign adr_ph  = (state == ST_ADR1) || (state == ST_ADR2);

    always_comb begin
        dal_out = '0;
        dal_oe  = 1'b0;
        if (adr_ph) begin
            dal_out = addr_q[DATA_W-1:0];
            dal_oe  = 1'b1;
        end else if (state == ST_DATA && write_q) begin
            dal_out = do_swap ? swap_halves(wdata_q) : wdata_q;
            dal_oe  = 1'b1;
        end
    end

    assign adr_hi = (adr_ph || state == ST_DATA) ? addr_q[ADDR_W-1:DATA_W] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (state == ST_DATA && ready && !write_q) begin
            rd_data <= do_swap ? swap_halves(dal_in) : dal_in;
        end
    end
endmodule

// File: rtl/bus_master_strobe.sv
module bus_master_strobe
    import bmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic              req_upper,
    input  logic              req_fifo,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_byte_pins,
    input  logic              cfg_pulse_strobe,
    input  logic              cfg_swap,
    input  logic              hlda,
    input  logic              ready,
    input  logic [DATA_W-1:0] dal_in,
    output logic              hold,
    output logic [DATA_W-1:0] dal_out,
    output logic              dal_oe,
    output logic [HI_W-1:0]   adr_hi,
    output logic              strobe,
    output logic              lane0,
    output logic              lane1,
    output logic              pins_oe,
    output logic              lane1_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              req_err
);
    bus_st_e state;
    xfer_t   xq;
    logic    master;
    logic    idle;
    logic    illegal;
    logic    start;

    assign idle    = (state == ST_IDLE);
    assign illegal = bad_combo(cfg_byte_pins, req_byte, req_addr[0]);
    assign start   = req_valid & idle & ~illegal;

    always_ff @(posedge clk) begin
        if (rst) begin
            xq      <= '0;
            req_err <= 1'b0;
        end else begin
            req_err <= req_valid & idle & illegal;
            if (start) begin
                xq.addr      <= req_addr;
                xq.write     <= req_write;
                xq.is_byte   <= req_byte;
                xq.upper     <= req_upper;
                xq.fifo      <= req_fifo;
                xq.byte_pins <= cfg_byte_pins;
                xq.pulse     <= cfg_pulse_strobe;
                xq.swap      <= cfg_swap;
                xq.wdata     <= req_wdata;
            end
        end
    end

    bmc_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .hlda   (hlda),
        .ready  (ready),
        .state  (state),
        .hold   (hold),
        .master (master),
        .done   (done)
    );

    bmc_lanes u_lanes (
        .clk           (clk),
        .rst           (rst),
        .state         (state),
        .master        (master),
        .hold          (hold),
        .hlda          (hlda),
        .cfg_byte_pins (cfg_byte_pins),
        .byte_pins_q   (xq.byte_pins),
        .pulse_q       (xq.pulse),
        .is_byte_q     (xq.is_byte),
        .upper_q       (xq.upper),
        .a0_q          (xq.addr[0]),
        .strobe        (strobe),
        .lane0         (lane0),
        .lane1         (lane1),
        .pins_oe       (pins_oe),
        .lane1_oe      (lane1_oe)
    );

    bmc_data u_data (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .ready   (ready),
        .addr_q  (xq.addr),
        .write_q (xq.write),
        .fifo_q  (xq.fifo),
        .swap_q  (xq.swap),
        .wdata_q (xq.wdata),
        .dal_in  (dal_in),
        .dal_out (dal_out),
        .dal_oe  (dal_oe),
        .adr_hi  (adr_hi),
        .rd_data (rd_data)
    );

    // R6
    err_no_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_err |-> !hold);
endmodule

// File: tb/sim_bus_master_strobe.sv
`timescale 1ns/1ps
module sim_bus_master_strobe;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_byte, req_upper, req_fifo;
    logic [23:0] req_addr;
    logic [15:0] req_wdata, dal_in;
    logic        cfg_byte_pins, cfg_pulse_strobe, cfg_swap, hlda, ready;
    logic        hold, dal_oe, strobe, lane0, lane1, pins_oe, lane1_oe, done, req_err;
    logic [15:0] dal_out, rd_data;
    logic [7:0]  adr_hi;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    bus_master_strobe u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_byte(req_byte), .req_upper(req_upper),
        .req_fifo(req_fifo), .req_wdata(req_wdata), .cfg_byte_pins(cfg_byte_pins),
        .cfg_pulse_strobe(cfg_pulse_strobe), .cfg_swap(cfg_swap), .hlda(hlda),
        .ready(ready), .dal_in(dal_in), .hold(hold), .dal_out(dal_out),
        .dal_oe(dal_oe), .adr_hi(adr_hi), .strobe(strobe), .lane0(lane0),
        .lane1(lane1), .pins_oe(pins_oe), .lane1_oe(lane1_oe), .rd_data(rd_data),
        .done(done), .req_err(req_err)
    );

    typedef struct packed {
        logic bcon, acon, bswp, fifo, wr, isb, up;
        logic [23:0] addr;
        logic [15:0] wd, bus;
        logic [1:0]  lanes;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 24'h123456, 16'hA1B2, 16'h0000, 2'b00, 16'hA1B2},
        {1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 24'hABCDEF, 16'h1234, 16'h0000, 2'b00, 16'h1234},
        {1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 24'h000100, 16'h1234, 16'h0000, 2'b00, 16'h3412},
        {1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 24'h000010, 16'h0000, 16'hC3D4, 2'b01, 16'hC3D4},
        {1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 24'h000013, 16'h0000, 16'hC3D4, 2'b10, 16'hD4C3},
        {1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 24'h000021, 16'h00EE, 16'h0000, 2'b11, 16'h00EE},
        {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 24'h7F0040, 16'h0000, 16'h5A5A, 2'b10, 16'h5A5A},
        {1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 24'h000002, 16'h0000, 16'h1122, 2'b11, 16'h2211}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        cfg_byte_pins = v.bcon; cfg_pulse_strobe = v.acon; cfg_swap = v.bswp;
        req_fifo = v.fifo; req_write = v.wr; req_byte = v.isb; req_upper = v.up;
        req_addr = v.addr; req_wdata = v.wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 hold after request", {31'd0, hold}, 32'd1);
        check("R1 no drive before grant", {31'd0, pins_oe}, 32'd0);
        @(negedge clk);
        check("R1 still waiting for grant", {30'd0, hold, pins_oe}, 32'd2);
        hlda = 1'b1;
        @(negedge clk);
        hlda = 1'b0;
        check("R10 pins driven in address phase", {30'd0, pins_oe, lane1_oe}, 32'd3);
        check("R2 R8 address low on bus", {15'd0, dal_oe, dal_out}, {15'd0, 1'b1, v.addr[15:0]});
        check("R2 upper address", {24'd0, adr_hi}, {24'd0, v.addr[23:16]});
        check("R3 R4 strobe first address cycle", {31'd0, strobe}, {31'd0, ~v.acon});
        check("R5 R6 R7 lane code", {30'd0, lane1, lane0}, {30'd0, v.lanes});
        @(negedge clk);
        check("R2 second address cycle", {15'd0, dal_oe, dal_out}, {15'd0, 1'b1, v.addr[15:0]});
        check("R3 R4 strobe second address cycle", {31'd0, strobe}, {31'd0, v.acon});
        @(negedge clk);
        dal_in = v.bus;
        check("R3 R4 strobe data phase", {31'd0, strobe}, {31'd0, v.acon});
        if (v.wr) check("R8 R9 write data on bus", {15'd0, dal_oe, dal_out}, {15'd0, 1'b1, v.exp});
        else      check("R9 read releases bus", {31'd0, dal_oe}, 32'd0);
        @(negedge clk);
        check("R9 data phase waits for ready", {29'd0, hold, pins_oe, done}, 32'd6);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        check("R9 completion", {30'd0, done, hold}, 32'd2);
        if (!v.wr) check("R8 R9 read word", {16'd0, rd_data}, {16'd0, v.exp});
        @(negedge clk);
        check("R9 done is one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0; req_upper = 1'b0;
        req_fifo = 1'b0; req_addr = '0; req_wdata = '0; dal_in = '0;
        cfg_byte_pins = 1'b0; cfg_pulse_strobe = 1'b0; cfg_swap = 1'b0;
        hlda = 1'b0; ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset idle pins", {27'd0, hold, pins_oe, lane1_oe, dal_oe, done}, 32'd0);
        check("R6 reset no error", {31'd0, req_err}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6 illegal combination is rejected
        @(negedge clk);
        cfg_byte_pins = 1'b1; req_byte = 1'b0; req_addr = 24'h000031; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 illegal request flagged", {30'd0, req_err, hold}, 32'd2);
        @(negedge clk);
        check("R6 no cycle for illegal request", {29'd0, req_err, hold, pins_oe}, 32'd0);

        // R7 chain output while idle
        hlda = 1'b1;
        @(negedge clk);
        check("R7 grant passed downstream", {30'd0, lane1, lane1_oe}, 32'd1);
        hlda = 1'b0;
        @(negedge clk);
        check("R7 chain high without grant", {31'd0, lane1}, 32'd1);

        // R10 byte-mask mode idle: nothing driven
        cfg_byte_pins = 1'b0;
        @(negedge clk);
        check("R10 byte-mask idle undriven", {30'd0, pins_oe, lane1_oe}, 32'd0);

        finish_run();
    end
endmodule